// File: doc/BRIEF.md
# Tunneled Device Configuration Access Controller

This block sits on the host side of a serial peripheral link. Through it, software can read or write configuration registers on any one of up to four attached devices. Software first fills a data word when it has a write payload. It then writes a control word that selects the device, the access type and the 12-bit register address, with the start bit set. The block checks that request against a sticky write lock. It then either issues exactly one request to the link engine over a valid/ready handshake or finishes at once with a refusal code. Software reads the completion from a three-bit status field and must clear that field before it can start the next access.

The lock protects only the low, specification-defined part of the configuration space. Writes to addresses up to 0x7FF are refused while it is set. Writes to higher addresses, and every read or status query, still go through. For reads and status queries, the 32-bit value that comes back is kept in the data word, where software can read it.

Top module: `cfgtun_ctrl`

## Requirements
- R1: After reset, the control readback and the data readback are both zero and no link request is raised.
- R2: Control bits 26:21, 18 and 15:12 always read as zero, and writing ones to them has no effect.
- R3: When idle with zero status, a control write with bit 31 set raises `lnk_req_valid` one cycle later. The request carries device bits 20:19, type bits 17:16 and address bits 11:0 from that same write, plus the data word as payload. The request holds steady until `lnk_req_ready` is seen, and exactly one handshake occurs per access.
- R4: Control bit 31 reads 1 from the cycle after launch until the completion edge, and it returns to 0 in the same cycle that the status is set.
- R5: Status bits 30:28 become 001 on a response without error and 100 on a response with `lnk_rsp_err` set.
- R6: For type 00 (read) or 10 (status query), an error-free response value is stored in the data word. A type 01 (write) leaves the data word unchanged.
- R7: Control bit 27 (lock) is set by writing 1, stays set when 0 is written, and is cleared only by reset.
- R8: With the lock set (including when it is set by the same write), a type 01 access to an address at or below 0x7FF raises no request and sets status 010.
- R9: With the lock set, writes above 0x7FF, and reads and status queries at any address, are issued and complete normally.
- R10: A start with type 11 raises no request and sets status 100.
- R11: A control write with bit 31 set, issued while status is non-zero or while an access is in flight, is ignored entirely. Control state and request activity stay as they were.
- R12: Writing 1 to a status bit clears that bit. A control write without bit 31 set never starts an access.
- R13: While an access is in flight, writes to the data word and to the device, type and address fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_sel | input | 1 | Write target: 0 = control word, 1 = data word |
| sw_wdata | input | 32 | Software write value |
| ctrl_rdata | output | 32 | Control word readback |
| data_rdata | output | 32 | Data word readback |
| lnk_req_valid | output | 1 | Request to the link engine is pending |
| lnk_req_ready | input | 1 | Link engine accepts the request |
| lnk_dev | output | 2 | Target device select |
| lnk_type | output | 2 | Access type (00 read, 01 write, 10 status) |
| lnk_addr | output | 12 | Configuration register address |
| lnk_wdata | output | 32 | Write payload |
| lnk_rsp_valid | input | 1 | Response from the link engine |
| lnk_rsp_err | input | 1 | Response reports an error |
| lnk_rsp_data | input | 32 | Response value |

## Verification
Every result is registered exactly once. A control write presented before a rising edge shows up in `ctrl_rdata` and `lnk_req_valid` after that edge. Immediate refusals appear in the status the cycle after the start write. A request drops, and a completion status and data word appear, one cycle after the edge that samples `lnk_req_ready` or `lnk_rsp_valid`. The bench drives every stimulus on a falling edge and samples at the next falling edge, so each check lands in the cycle just after the edge that produces its result.

// File: rtl/cfgtun_pkg.sv
package cfgtun_pkg;
   typedef enum logic [1:0] {
      ACC_RD   = 2'b00,
      ACC_WR   = 2'b01,
      ACC_STAT = 2'b10,
      ACC_RSVD = 2'b11
   } acc_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_REQ,
      PH_RSP
   } phase_t;

   typedef enum logic [1:0] {
      V_LAUNCH,
      V_BLOCK,
      V_BADTYPE
   } verdict_t;

   localparam logic [2:0] ST_DONE  = 3'b001;
   localparam logic [2:0] ST_BLOCK = 3'b010;
   localparam logic [2:0] ST_FAIL  = 3'b100;

   localparam int GO_BIT   = 31;
   localparam int STAT_LO  = 28;
   localparam int LOCK_BIT = 27;
   localparam int DEV_LO   = 19;
   localparam int TYPE_LO  = 16;
endpackage

// File: rtl/cfgtun_guard.sv
module cfgtun_guard
   import cfgtun_pkg::*;
#(
   parameter int              ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] LOCK_TOP = 'h7FF,
   parameter bit              LOCK_EN  = 1'b1
) (
   input  acc_t              typ,
   input  logic [ADDR_W-1:0] addr,
   input  logic              lock,
   output verdict_t          verdict
);
   logic in_window;

   generate
      if (LOCK_EN) begin : g_lock
         assign in_window = lock && (addr <= LOCK_TOP);
      end else begin : g_nolock
         logic unused_lock;
         assign unused_lock = lock ^ (^addr);
         assign in_window   = 1'b0;
      end
   endgenerate

   always_comb begin
      if (typ == ACC_RSVD)
         verdict = V_BADTYPE;
      else if (typ == ACC_WR && in_window)
         verdict = V_BLOCK;
      else
         verdict = V_LAUNCH;
   end
endmodule

// File: rtl/cfgtun_regs.sv
module cfgtun_regs
   import cfgtun_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int DEV_W   = 2,
   parameter int DATA_W  = 32,
   parameter bit LOCK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fld_we,
   input  logic              lock_set,
   input  logic              data_we,
   input  logic [31:0]       wdata,
   input  logic              latch_en,
   input  logic [DATA_W-1:0] rsp_data,
   output logic [DEV_W-1:0]  dev_q,
   output acc_t              typ_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              lock_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_q  <= '0;
         typ_q  <= ACC_RD;
         addr_q <= '0;
      end else if (fld_we) begin
         dev_q  <= wdata[DEV_LO +: DEV_W];
         typ_q  <= acc_t'(wdata[TYPE_LO +: 2]);
         addr_q <= wdata[ADDR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= '0;
      else if (latch_en)
         data_q <= rsp_data;
      else if (data_we)
         data_q <= wdata[DATA_W-1:0];
   end

   generate
      if (LOCK_EN) begin : g_lock
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lock_q <= 1'b0;
            else if (lock_set)
               lock_q <= 1'b1;
         end
      end else begin : g_nolock
         logic unused_set;
         assign unused_set = lock_set;
         assign lock_q     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cfgtun_seq.sv
module cfgtun_seq
   import cfgtun_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_fire,
   input  verdict_t   verdict,
   input  logic [2:0] clr_mask,
   input  logic       req_ready,
   input  logic       rsp_valid,
   input  logic       rsp_err,
   output logic       busy,
   output logic       req_valid,
   output logic       done_ok,
   output logic [2:0] status
);
   phase_t phase;
   logic   rsp_take;

   assign busy      = (phase != PH_IDLE);
   assign req_valid = (phase == PH_REQ);
   assign rsp_take  = (phase == PH_RSP) && rsp_valid;
   assign done_ok   = rsp_take && !rsp_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         status <= 3'b000;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (go_fire) begin
                  unique case (verdict)
                     V_LAUNCH:  phase  <= PH_REQ;
                     V_BLOCK:   status <= ST_BLOCK;
                     default:   status <= ST_FAIL;
                  endcase
               end else begin
                  status <= status & ~clr_mask;
               end
            end
            PH_REQ: begin
               if (req_ready)
                  phase <= PH_RSP;
            end
            default: begin
               if (rsp_take) begin
                  phase  <= PH_IDLE;
                  status <= rsp_err ? ST_FAIL : ST_DONE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cfgtun_ctrl.sv
module cfgtun_ctrl
   import cfgtun_pkg::*;
#(
   parameter int                ADDR_W   = 12,
   parameter int                DEV_W    = 2,
   parameter int                DATA_W   = 32,
   parameter bit                LOCK_EN  = 1'b1,
   parameter logic [ADDR_W-1:0] LOCK_TOP = 'h7FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr_en,
   input  logic              sw_sel,
   input  logic [31:0]       sw_wdata,
   output logic [31:0]       ctrl_rdata,
   output logic [DATA_W-1:0] data_rdata,
   output logic              lnk_req_valid,
   input  logic              lnk_req_ready,
   output logic [DEV_W-1:0]  lnk_dev,
   output logic [1:0]        lnk_type,
   output logic [ADDR_W-1:0] lnk_addr,
   output logic [DATA_W-1:0] lnk_wdata,
   input  logic              lnk_rsp_valid,
   input  logic              lnk_rsp_err,
   input  logic [DATA_W-1:0] lnk_rsp_data
);
   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("cfgtun_ctrl: ADDR_W must lie in 1..12");
      end
      if (DEV_W < 1 || DEV_W > 2) begin : g_bad_dev
         $error("cfgtun_ctrl: DEV_W must lie in 1..2");
      end
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
         $error("cfgtun_ctrl: DATA_W must lie in 1..32");
      end
   endgenerate

   logic              busy, done_ok, ctrl_we, go_req, drop, ctrl_ok;
   logic              go_fire, fld_we, lock_set, data_we, latch_en;
   logic [2:0]        status, clr_mask;
   logic [DEV_W-1:0]  dev_q;
   acc_t              typ_q;
   logic [ADDR_W-1:0] addr_q;
   logic              lock_q;
   logic [DATA_W-1:0] data_q;
   verdict_t          verdict;
   logic              unused_wdata;

   assign unused_wdata = ^sw_wdata;

   // Control write decode: a start that cannot be honoured drops the whole write.
   assign ctrl_we  = sw_wr_en && !sw_sel;
   assign go_req   = ctrl_we && sw_wdata[GO_BIT];
   assign drop     = go_req && (busy || (status != 3'b000));
   assign ctrl_ok  = ctrl_we && !drop;
   assign go_fire  = ctrl_ok && sw_wdata[GO_BIT];
   assign fld_we   = ctrl_ok && !busy;
   assign lock_set = ctrl_ok && sw_wdata[LOCK_BIT];
   assign clr_mask = ctrl_ok ? sw_wdata[STAT_LO +: 3] : 3'b000;
   assign data_we  = sw_wr_en && sw_sel && !busy;
   assign latch_en = done_ok && (typ_q != ACC_WR);

   cfgtun_guard #(
      .ADDR_W   (ADDR_W),
      .LOCK_TOP (LOCK_TOP),
      .LOCK_EN  (LOCK_EN)
   ) u_guard (
      .typ     (acc_t'(sw_wdata[TYPE_LO +: 2])),
      .addr    (sw_wdata[ADDR_W-1:0]),
      .lock    (lock_q || sw_wdata[LOCK_BIT]),
      .verdict (verdict)
   );

   cfgtun_regs #(
      .ADDR_W  (ADDR_W),
      .DEV_W   (DEV_W),
      .DATA_W  (DATA_W),
      .LOCK_EN (LOCK_EN)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .fld_we   (fld_we),
      .lock_set (lock_set),
      .data_we  (data_we),
      .wdata    (sw_wdata),
      .latch_en (latch_en),
      .rsp_data (lnk_rsp_data),
      .dev_q    (dev_q),
      .typ_q    (typ_q),
      .addr_q   (addr_q),
      .lock_q   (lock_q),
      .data_q   (data_q)
   );

   cfgtun_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_fire   (go_fire),
      .verdict   (verdict),
      .clr_mask  (clr_mask),
      .req_ready (lnk_req_ready),
      .rsp_valid (lnk_rsp_valid),
      .rsp_err   (lnk_rsp_err),
      .busy      (busy),
      .req_valid (lnk_req_valid),
      .done_ok   (done_ok),
      .status    (status)
   );

   always_comb begin
      ctrl_rdata                  = '0;
      ctrl_rdata[GO_BIT]          = busy;
      ctrl_rdata[STAT_LO +: 3]    = status;
      ctrl_rdata[LOCK_BIT]        = lock_q;
      ctrl_rdata[DEV_LO +: DEV_W] = dev_q;
      ctrl_rdata[TYPE_LO +: 2]    = typ_q;
      ctrl_rdata[ADDR_W-1:0]      = addr_q;
   end

   assign data_rdata = data_q;
   assign lnk_dev    = dev_q;
   assign lnk_type   = typ_q;
   assign lnk_addr   = addr_q;
   assign lnk_wdata  = data_q;
endmodule

// File: rtl/cfgtun_ctrl_chk.sv
module cfgtun_ctrl_chk #(
   parameter int                ADDR_W   = 12,
   parameter int                DEV_W    = 2,
   parameter int                DATA_W   = 32,
   parameter bit                LOCK_EN  = 1'b1,
   parameter logic [ADDR_W-1:0] LOCK_TOP = 'h7FF
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       ctrl_rdata,
   input logic              lnk_req_valid,
   input logic              lnk_req_ready,
   input logic [DEV_W-1:0]  lnk_dev,
   input logic [1:0]        lnk_type,
   input logic [ADDR_W-1:0] lnk_addr,
   input logic [DATA_W-1:0] lnk_wdata
);
   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_req_valid && !lnk_req_ready) |=>
         (lnk_req_valid && $stable(lnk_dev) && $stable(lnk_type)
          && $stable(lnk_addr) && $stable(lnk_wdata)));

   a_r4_go_while_req: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_req_valid |-> ctrl_rdata[31]);

   a_r5_status_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctrl_rdata[30:28]));

   a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_rdata[27]) |-> ctrl_rdata[27]);

   a_r8_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lnk_req_valid) && lnk_type == 2'b01 && LOCK_EN && ctrl_rdata[27])
         |-> (lnk_addr > LOCK_TOP));

   a_r10_no_bad_type: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_req_valid |-> (lnk_type != 2'b11));

   a_r11_busy_clean_status: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rdata[31] |-> (ctrl_rdata[30:28] == 3'b000));
endmodule

bind cfgtun_ctrl cfgtun_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .DEV_W    (DEV_W),
   .DATA_W   (DATA_W),
   .LOCK_EN  (LOCK_EN),
   .LOCK_TOP (LOCK_TOP)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctrl_rdata    (ctrl_rdata),
   .lnk_req_valid (lnk_req_valid),
   .lnk_req_ready (lnk_req_ready),
   .lnk_dev       (lnk_dev),
   .lnk_type      (lnk_type),
   .lnk_addr      (lnk_addr),
   .lnk_wdata     (lnk_wdata)
);

// File: tb/cfgtun_ctrl_tb.sv
module cfgtun_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr_en = 1'b0, sw_sel = 1'b0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] ctrl_rdata, data_rdata, lnk_wdata, lnk_rsp_data = '0;
   logic        lnk_req_valid, lnk_req_ready = 1'b0;
   logic        lnk_rsp_valid = 1'b0, lnk_rsp_err = 1'b0;
   logic [1:0]  lnk_dev, lnk_type;
   logic [11:0] lnk_addr;

   int n_chk = 0, n_fail = 0, n_req = 0;
   bit done = 1'b0;
   bit lock_m = 1'b0;
   logic [31:0] data_m = '0;

   always #4 clk = ~clk;

   cfgtun_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_sel(sw_sel),
      .sw_wdata(sw_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
      .lnk_req_valid(lnk_req_valid), .lnk_req_ready(lnk_req_ready),
      .lnk_dev(lnk_dev), .lnk_type(lnk_type), .lnk_addr(lnk_addr),
      .lnk_wdata(lnk_wdata), .lnk_rsp_valid(lnk_rsp_valid),
      .lnk_rsp_err(lnk_rsp_err), .lnk_rsp_data(lnk_rsp_data)
   );

   always @(posedge clk) if (lnk_req_valid && lnk_req_ready) n_req++;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] cw(bit go, logic [2:0] st, bit lk,
                                      logic [1:0] dv, logic [1:0] ty, logic [11:0] ad);
      return {go, st, lk, 6'b0, dv, 1'b0, ty, 4'b0, ad};
   endfunction

   task automatic sw_write(bit sel, logic [31:0] v);
      @(negedge clk);
      sw_wr_en = 1'b1; sw_sel = sel; sw_wdata = v;
      @(negedge clk);
      sw_wr_en = 1'b0;
   endtask

   task automatic access(logic [1:0] dv, logic [1:0] ty, logic [11:0] ad, bit err);
      logic [31:0] pay, rd;
      logic [2:0]  st;
      bit          launch;
      int          req0;
      pay = 32'h5A00_0000 ^ {20'h0, ad} ^ {dv, ty, 20'h0};
      rd  = 32'hC300_0000 ^ {16'h0, ad, 4'h0} ^ {24'h0, dv, ty, 4'h0};
      launch = (ty != 2'b11) && !(ty == 2'b01 && lock_m && ad <= 12'h7FF);
      sw_write(1'b1, pay);
      data_m = pay;
      req0 = n_req;
      sw_write(1'b0, cw(1'b1, 3'b000, 1'b0, dv, ty, ad));
      if (launch) begin
         chk("R3 req raised", {31'b0, lnk_req_valid}, 32'd1);
         chk("R3 req fields", {lnk_dev, lnk_type, lnk_addr, 16'h0}, {dv, ty, ad, 16'h0});
         chk("R3 payload", lnk_wdata, pay);
         chk("R4 go while busy", ctrl_rdata, cw(1'b1, 3'b000, lock_m, dv, ty, ad));
         sw_write(1'b1, ~pay);
         chk("R13 data frozen", data_rdata, pay);
         sw_write(1'b0, cw(1'b0, 3'b000, 1'b0, ~dv, 2'b00, ~ad));
         chk("R13 fields frozen", ctrl_rdata, cw(1'b1, 3'b000, lock_m, dv, ty, ad));
         sw_write(1'b0, cw(1'b1, 3'b000, 1'b0, ~dv, 2'b00, ~ad));
         chk("R11 go while busy", ctrl_rdata, cw(1'b1, 3'b000, lock_m, dv, ty, ad));
         chk("R3 held", {31'b0, lnk_req_valid}, 32'd1);
         lnk_req_ready = 1'b1;
         @(negedge clk);
         lnk_req_ready = 1'b0;
         chk("R3 req dropped", {31'b0, lnk_req_valid}, 32'd0);
         lnk_rsp_valid = 1'b1; lnk_rsp_err = err; lnk_rsp_data = rd;
         @(negedge clk);
         lnk_rsp_valid = 1'b0; lnk_rsp_err = 1'b0;
         st = err ? 3'b100 : 3'b001;
         if (!err && ty != 2'b01) data_m = rd;
         chk(err ? "R5 error status" : "R5 done status", ctrl_rdata, cw(1'b0, st, lock_m, dv, ty, ad));
         chk(ty == 2'b01 ? "R6 write keeps data" : "R6 read latch", data_rdata, data_m);
         chk(lock_m ? "R9 single request" : "R3 single request", n_req - req0, 1);
      end else begin
         st = (ty == 2'b11) ? 3'b100 : 3'b010;
         chk(ty == 2'b11 ? "R10 bad type" : "R8 locked write", ctrl_rdata, cw(1'b0, st, lock_m, dv, ty, ad));
         chk(ty == 2'b11 ? "R10 no req" : "R8 no req", {31'b0, lnk_req_valid}, 32'd0);
      end
      sw_write(1'b0, cw(1'b1, 3'b000, 1'b0, ~dv, 2'b00, ~ad));
      chk("R11 go with status set", ctrl_rdata, cw(1'b0, st, lock_m, dv, ty, ad));
      chk("R11 no req", {31'b0, lnk_req_valid}, 32'd0);
      chk("R11 no handshake", n_req - req0, launch ? 1 : 0);
      sw_write(1'b0, cw(1'b0, 3'b111, 1'b0, dv, ty, ad));
      chk("R12 status cleared", ctrl_rdata, cw(1'b0, 3'b000, lock_m, dv, ty, ad));
      chk("R12 no start", {31'b0, lnk_req_valid}, 32'd0);
      chk("R13 data kept", data_rdata, data_m);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ctrl reset", ctrl_rdata, 32'h0);
      chk("R1 data reset", data_rdata, 32'h0);
      chk("R1 no req", {31'b0, lnk_req_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int pass = 0; pass < 2; pass++) begin
         for (int dv = 0; dv < 4; dv++)
            for (int ty = 0; ty < 4; ty++)
               for (int ai = 0; ai < 4; ai++) begin
                  logic [11:0] ad;
                  ad = (ai == 0) ? 12'h000 : (ai == 1) ? 12'h7FF : (ai == 2) ? 12'h800 : 12'hFFF;
                  access(dv[1:0], ty[1:0], ad, ((dv + ai + ty) % 3) == 0);
               end
         if (pass == 0) begin
            sw_write(1'b0, 32'h7FFF_FFFF);
            lock_m = 1'b1;
            chk("R2 reserved zero, R7 lock set", ctrl_rdata, 32'h081B_0FFF);
            sw_write(1'b0, 32'h0);
            chk("R7 lock sticky", ctrl_rdata, 32'h0800_0000);
         end
      end
      lock_m = 1'b0;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R7 reset clears lock", ctrl_rdata, 32'h0);
      chk("R1 data reset again", data_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      sw_write(1'b0, cw(1'b1, 3'b000, 1'b1, 2'd2, 2'b01, 12'h010));
      chk("R8 lock in same write", ctrl_rdata, cw(1'b0, 3'b010, 1'b1, 2'd2, 2'b01, 12'h010));
      chk("R8 no req same write", {31'b0, lnk_req_valid}, 32'd0);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule